// File: doc/BRIEF.md
# Port Input/Output Bus Cycle Sequencer

This block produces the external bus activity of a single port-input or port-output instruction on an 8-bit processor. The processor's bus multiplexes the low address byte with the data byte. A request carries four things: the direction, the 8-bit port number, the byte to write (for an output), and the address of the instruction in memory. From these the block steps through three machine cycles and ten T-states, one T-state per clock. The cycles are an opcode fetch from the instruction address, a memory read of the port byte from the next address, and an I/O cycle. The I/O cycle reads for an input and writes for an output.

The block does not use the bytes returned by the two memory cycles, because the request already supplies them. The two memory cycles are there only so the bus carries the correct address and strobe pattern. In the I/O cycle the port number appears on both the low and the high address lanes, so a device can decode its port from the high lane alone. An input transfer samples the bus at the end of the read strobe's T-state. The sampled byte is held on an output until the next input transfer.

Requests arrive on a valid/ready handshake. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. `req_ready` stays low for the whole ten-T-state sequence, so an upstream source must hold its request until ready returns. Any request presented while the block is busy has no effect. Completion is a one-clock `done` pulse with no back-pressure. A consumer that wants the input byte reads `in_data` during or after that pulse.

Top module: `iob_port_sequencer`

## Requirements
- R1: While in reset and after it, with no request: `req_ready`=1, `ale`=0, `rd_n`=1, `wr_n`=1, `io_m`=0, `ad_oe`=0, `done`=0, `a_hi`=0, `in_data`=0.
- R2: A request is accepted on an edge with `req_valid`=1 and `req_ready`=1. T-states 1..10 occupy the next ten clocks. `req_ready` is 0 throughout them and returns to 1 on the clock after T-state 10. `done` is 1 only in T-state 10.
- R3: `ale` is 1 exactly in the first T-state of each machine cycle, which is sequence T-states 1, 5 and 8, giving three pulses per instruction.
- R4: In the opcode fetch (T-states 1..4), `a_hi` carries bits 15:8 of the instruction address. In the port-byte read (T-states 5..7), `a_hi` carries bits 15:8 of the instruction address plus one, wrapping at 16 bits. In each cycle's first T-state, `ad_o` carries the matching low byte with `ad_oe`=1.
- R5: `io_m` is 0 in the two memory cycles and 1 in all three T-states of the I/O cycle (T-states 8..10).
- R6: In T-state 8 the port number is on both `ad_o` (with `ad_oe`=1) and `a_hi`. `a_hi` keeps the port number through T-state 10.
- R7: `rd_n` is 0 in the second T-state of each memory cycle (T-states 2 and 6) with `ad_oe`=0. For an input it is also 0 in T-state 9. It is 1 in every other T-state.
- R8: For an input (`req_dir`=0), the `ad_i` value present during T-state 9 appears on `in_data` from T-state 10 on. It stays unchanged through later output transfers.
- R9: For an output (`req_dir`=1), `wr_n` is 0 exactly in T-state 9, and `rd_n` stays 1 throughout the I/O cycle. `ad_o` carries the write byte with `ad_oe`=1 in T-states 9 and 10.
- R10: `rd_n` and `wr_n` are never 0 together, and neither is 0 while `ale` is 1.
- R11: Direction, port, write byte and address are captured at acceptance. Changing those inputs while busy does not alter the bus sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_dir | input | 1 | 0 = port input, 1 = port output |
| req_port | input | 8 | Port number |
| req_wdata | input | 8 | Byte to write for an output |
| req_pc | input | 16 | Address of the instruction's first byte |
| done | output | 1 | One-clock pulse in the final T-state |
| in_data | output | 8 | Byte captured by the last input transfer |
| ad_o | output | 8 | Multiplexed low address / data, driven value |
| ad_oe | output | 1 | Drive enable for `ad_o` |
| ad_i | input | 8 | Multiplexed low lane as seen from the bus |
| a_hi | output | 8 | High address lane |
| ale | output | 1 | Address latch enable |
| io_m | output | 1 | 1 = I/O cycle, 0 = memory cycle |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |

## Verification
Each transfer is checked T-state by T-state against an expected bus table derived from the requirements, so the checks show whether each signal is driven in the correct cycle and not just once somewhere. The tests cover an input and an output, which separates the read-strobe and write-strobe paths of the I/O cycle. They use an instruction address whose low byte is 0xFF, which exposes a missing carry into the high lane, and an address of 0xFFFF, which exercises the 16-bit wrap. During each transfer the bench drives a different byte on `ad_i` in every T-state except T-state 9, so a capture taken one cycle early or late shows up as a wrong value. Each transfer also scrambles the request inputs and pulses `req_valid` while the block is busy, which shows whether the block captured the request at acceptance and whether it ignores a request presented while busy.

// File: rtl/iob_seq_pkg.sv
package iob_seq_pkg;
  typedef enum logic [1:0] {
    MC_FETCH = 2'd0,
    MC_MRD   = 2'd1,
    MC_IO    = 2'd2
  } mcyc_e;
endpackage

// File: rtl/iob_cycle_timer.sv
module iob_cycle_timer
  import iob_seq_pkg::*;
#(
  parameter int T_FETCH = 4,
  parameter int T_MRD   = 3,
  parameter int T_IO    = 3,
  parameter int TS_W    = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output logic            active,
  output mcyc_e           mc,
  output logic [TS_W-1:0] ts,
  output logic            seq_last
);
  logic [TS_W-1:0] len_m1;
  logic            cyc_last;

  always_comb begin
    case (mc)
      MC_FETCH: len_m1 = TS_W'(T_FETCH - 1);
      MC_MRD:   len_m1 = TS_W'(T_MRD - 1);
      default:  len_m1 = TS_W'(T_IO - 1);
    endcase
  end

  assign cyc_last = (ts == len_m1);
  assign seq_last = active && cyc_last && (mc == MC_IO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      mc     <= MC_FETCH;
      ts     <= '0;
    end else if (start && !active) begin
      active <= 1'b1;
      mc     <= MC_FETCH;
      ts     <= '0;
    end else if (active) begin
      if (cyc_last) begin
        ts <= '0;
        case (mc)
          MC_FETCH: mc <= MC_MRD;
          MC_MRD:   mc <= MC_IO;
          default: begin
            mc     <= MC_FETCH;
            active <= 1'b0;
          end
        endcase
      end else begin
        ts <= ts + 1'b1;
      end
    end
  end
endmodule

// File: rtl/iob_bus_driver.sv
module iob_bus_driver
  import iob_seq_pkg::*;
#(
  parameter int DW   = 8,
  parameter int TS_W = 3
) (
  input  logic            active,
  input  mcyc_e           mc,
  input  logic [TS_W-1:0] ts,
  input  logic            dir_out,
  input  logic [DW-1:0]   port,
  input  logic [DW-1:0]   wdata,
  input  logic [2*DW-1:0] pc,
  output logic [DW-1:0]   ad_o,
  output logic            ad_oe,
  output logic [DW-1:0]   a_hi,
  output logic            ale,
  output logic            io_m,
  output logic            rd_n,
  output logic            wr_n
);
  logic [2*DW-1:0] addr;
  logic            t1, t2, in_io, wr_cyc;

  always_comb begin
    case (mc)
      MC_FETCH: addr = pc;
      MC_MRD:   addr = pc + 1'b1;
      default:  addr = {port, port};
    endcase
  end

  assign t1     = active && (ts == '0);
  assign t2     = active && (ts == TS_W'(1));
  assign in_io  = active && (mc == MC_IO);
  assign wr_cyc = in_io && dir_out;

  assign ale   = t1;
  assign io_m  = in_io;
  assign a_hi  = active ? addr[2*DW-1:DW] : '0;
  assign ad_oe = t1 || (wr_cyc && !t1);
  assign ad_o  = t1 ? addr[DW-1:0] : (wr_cyc ? wdata : '0);
  assign rd_n  = !(t2 && !wr_cyc);
  assign wr_n  = !(t2 && wr_cyc);
endmodule

// File: rtl/iob_port_sequencer.sv
module iob_port_sequencer
  import iob_seq_pkg::*;
#(
  parameter int DW      = 8,
  parameter int T_FETCH = 4,
  parameter int T_MRD   = 3,
  parameter int T_IO    = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_dir,
  input  logic [DW-1:0]   req_port,
  input  logic [DW-1:0]   req_wdata,
  input  logic [2*DW-1:0] req_pc,
  output logic            done,
  output logic [DW-1:0]   in_data,
  output logic [DW-1:0]   ad_o,
  output logic            ad_oe,
  input  logic [DW-1:0]   ad_i,
  output logic [DW-1:0]   a_hi,
  output logic            ale,
  output logic            io_m,
  output logic            rd_n,
  output logic            wr_n
);
  localparam int TMAX = (T_FETCH > T_MRD) ? ((T_FETCH > T_IO) ? T_FETCH : T_IO)
                                          : ((T_MRD > T_IO) ? T_MRD : T_IO);
  localparam int TS_W = $clog2(TMAX + 1);

  logic            active, seq_last, accept, capture;
  mcyc_e           mc;
  logic [TS_W-1:0] ts;
  logic            dir_q;
  logic [DW-1:0]   port_q, wdata_q;
  logic [2*DW-1:0] pc_q;

  assign req_ready = !active;
  assign accept    = req_valid && req_ready;
  assign done      = seq_last;
  assign capture   = active && (mc == MC_IO) && (ts == TS_W'(1)) && !dir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= 1'b0;
      port_q  <= '0;
      wdata_q <= '0;
      pc_q    <= '0;
    end else if (accept) begin
      dir_q   <= req_dir;
      port_q  <= req_port;
      wdata_q <= req_wdata;
      pc_q    <= req_pc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       in_data <= '0;
    else if (capture) in_data <= ad_i;
  end

  iob_cycle_timer #(
    .T_FETCH(T_FETCH), .T_MRD(T_MRD), .T_IO(T_IO), .TS_W(TS_W)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .start(accept),
    .active(active), .mc(mc), .ts(ts), .seq_last(seq_last)
  );

  iob_bus_driver #(.DW(DW), .TS_W(TS_W)) u_drv (
    .active(active), .mc(mc), .ts(ts), .dir_out(dir_q),
    .port(port_q), .wdata(wdata_q), .pc(pc_q),
    .ad_o(ad_o), .ad_oe(ad_oe), .a_hi(a_hi), .ale(ale),
    .io_m(io_m), .rd_n(rd_n), .wr_n(wr_n)
  );
endmodule

// File: rtl/iob_port_seq_checker.sv
module iob_port_seq_checker #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          done,
  input logic [DW-1:0] ad_o,
  input logic          ad_oe,
  input logic [DW-1:0] a_hi,
  input logic          ale,
  input logic          io_m,
  input logic          rd_n,
  input logic          wr_n
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n)); // R10
  AST_ALE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (rd_n && wr_n)); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!ale && rd_n && wr_n && !io_m && !done)); // R1
  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> req_ready); // R2
  AST_IO_ENTRY_ALE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(io_m) |-> ale); // R5
  AST_IO_PORT_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    (ale && io_m) |-> (ad_oe && ad_o == a_hi)); // R6
  AST_WRITE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> (ad_oe && io_m)); // R9
  AST_READ_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe); // R7
endmodule

bind iob_port_sequencer iob_port_seq_checker #(.DW(DW)) u_chk (.*);

// File: tb/iob_port_sequencer_test.sv
module iob_port_sequencer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_dir = 1'b0;
  logic [7:0]  req_port = '0;
  logic [7:0]  req_wdata = '0;
  logic [15:0] req_pc = '0;
  logic        done;
  logic [7:0]  in_data, ad_o, ad_i, a_hi;
  logic        ad_oe, ale, io_m, rd_n, wr_n;
  int          checks = 0;
  int          failures = 0;

  always #2 clk = ~clk;

  iob_port_sequencer uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_dir(req_dir), .req_port(req_port), .req_wdata(req_wdata), .req_pc(req_pc),
    .done(done), .in_data(in_data), .ad_o(ad_o), .ad_oe(ad_oe), .ad_i(ad_i),
    .a_hi(a_hi), .ale(ale), .io_m(io_m), .rd_n(rd_n), .wr_n(wr_n)
  );

  task automatic chk(input string tag, input int k, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s T%0d actual=%0h expected=%0h", tag, k, act, exp);
    end
  endtask

  task automatic check_reset();
    @(negedge clk);
    chk("R1 ready", 0, req_ready, 1); chk("R1 ale", 0, ale, 0);
    chk("R1 rd_n", 0, rd_n, 1);       chk("R1 wr_n", 0, wr_n, 1);
    chk("R1 io_m", 0, io_m, 0);       chk("R1 ad_oe", 0, ad_oe, 0);
    chk("R1 done", 0, done, 0);       chk("R1 a_hi", 0, a_hi, 0);
    chk("R1 in_data", 0, in_data, 0);
  endtask

  // One transfer; expected bus per T-state built from the requirements.
  task automatic run_xfer(input logic dir, input logic [7:0] port,
                          input logic [7:0] wdata, input logic [15:0] pc,
                          input logic [7:0] dev, input logic [7:0] prev_in);
    logic [15:0] pc1 = pc + 16'd1;
    @(negedge clk);
    req_valid = 1'b1; req_dir = dir; req_port = port;
    req_wdata = wdata; req_pc = pc; ad_i = ~dev;
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      if (k == 1) begin // R11: scramble request inputs while busy
        req_valid = 1'b0; req_dir = ~dir; req_port = ~port;
        req_wdata = ~wdata; req_pc = ~pc;
      end
      if (k == 4) req_valid = 1'b1;   // R2: ignored while busy
      if (k == 5) req_valid = 1'b0;
      begin
        int  mcn = (k <= 4) ? 0 : ((k <= 7) ? 1 : 2);
        int  t   = (k <= 4) ? k - 1 : ((k <= 7) ? k - 5 : k - 8);
        logic [7:0] exp_hi = (mcn == 0) ? pc[15:8] : ((mcn == 1) ? pc1[15:8] : port);
        logic [7:0] exp_lo = (mcn == 0) ? pc[7:0] : ((mcn == 1) ? pc1[7:0] : port);
        logic exp_rd = !(t == 1 && !(mcn == 2 && dir));
        logic exp_wr = !(t == 1 && mcn == 2 && dir);
        logic exp_oe = (t == 0) || (mcn == 2 && dir);
        chk("R2 ready", k, req_ready, 0);
        chk("R2 done", k, done, (k == 10));
        chk("R3 ale", k, ale, (t == 0));
        chk("R5 io_m", k, io_m, (mcn == 2));
        chk((mcn == 2) ? "R6 a_hi" : "R4 a_hi", k, a_hi, exp_hi);
        chk(dir ? "R9 rd_n" : "R7 rd_n", k, rd_n, exp_rd);
        chk(dir ? "R9 wr_n" : "R7 wr_n", k, wr_n, exp_wr);
        chk("R10 strobes", k, (!rd_n && !wr_n) || (ale && (!rd_n || !wr_n)), 0);
        chk(dir ? "R9 ad_oe" : "R7 ad_oe", k, ad_oe, exp_oe);
        if (t == 0) chk((mcn == 2) ? "R6 ad_o" : "R4 ad_o", k, ad_o, exp_lo);
        else if (mcn == 2 && dir) chk("R9 ad_o", k, ad_o, wdata);
      end
      if (k == 9) ad_i = dev;
      if (k == 10) begin
        ad_i = ~dev;
        chk("R8 in_data", k, in_data, dir ? prev_in : dev);
      end
    end
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      chk("R2 ready after", 11 + j, req_ready, 1);
      chk("R2 no restart", 11 + j, ale, 0);
      chk("R8 in_data held", 11 + j, in_data, dir ? prev_in : dev);
    end
  endtask

  initial begin
    ad_i = 8'h00;
    repeat (3) @(negedge clk);
    check_reset();                         // R1 during reset
    rst_n = 1'b1;
    check_reset();                         // R1 after reset
    run_xfer(1'b0, 8'h0F, 8'h00, 16'h1234, 8'hA5, 8'h00); // input
    run_xfer(1'b1, 8'hFF, 8'h3C, 16'h20FF, 8'h77, 8'hA5); // output, carry
    run_xfer(1'b0, 8'h80, 8'h11, 16'hFFFF, 8'h5A, 8'hA5); // input, wrap
    run_xfer(1'b1, 8'h01, 8'hC3, 16'h0000, 8'h99, 8'h5A); // output keeps in_data
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule